// File: doc/BRIEF.md
# Symmetric Pipelined FIR Filter

This block is a 35-tap finite impulse response filter for 24-bit two's complement samples. It takes one new sample on every clock edge and produces one filtered sample per clock at a fixed latency. The coefficients are built in at elaboration time, as 16-bit signed constants. They are mirror-symmetric about the middle tap.

The filter uses that symmetry. Each pair of taps that share a coefficient is summed into a 25-bit value before a single multiply, so 18 multipliers serve all 35 taps. The 18 products, each 40 bits wide, are combined in a binary adder tree with a register after every level. No register-to-register path therefore holds more than one multiply or one 40-bit addition.

The output is the upper 24 bits of the 40-bit accumulated sum. The upper 24 bits are bits 39 down to 16 of that sum, so the 16 least significant bits are discarded. A host feeds samples continuously and reads the result eight edges later. A low level on the reset input at a clock edge returns the whole pipeline to zero.

Top module: `symFir`

## Requirements
- R1: While `rstN` is low at a rising edge, the input register, the delay line, every pipeline stage and `yOut` are cleared to zero. After reset, no sample taken before the reset contributes to any later output.
- R2: A sample on `xIn` at rising edge k first affects the value of `yOut` after rising edge k+7, which gives a latency of 8 edges including the capture edge. For the first 7 rising edges after reset is released, `yOut` is zero.
- R3: The tap coefficients c[0..17] are, in hex, 015F 0061 0033 FFF0 FF8C FED9 FE65 FE25 FE3B FEBF FFA8 0120 02D8 04B3 067A 07F2 08EB 0942, with c[34-k] = c[k]. An impulse of value 65536 followed by zeros reproduces c[0] through c[34] on `yOut` on consecutive cycles.
- R4: `yOut` equals bits 39:16 of the exact two's complement sum of c[k]·x[n-k]. This is the floor of the sum divided by 65536, so negative fractions round toward minus infinity. An input held at zero long enough gives an output of zero.
- R5: An input held constant for 44 consecutive edges produces a constant output equal to the step response of the filter.
- R6: Full-scale inputs of -8388608 and 8388607, in any pattern, give the exact result with no wrap in the 40-bit path.
- R7: A new sample is accepted on every edge with no stall. An arbitrary stream of samples yields the exact convolution, one output per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| xIn | input | 24 | Signed input sample, taken every edge |
| yOut | output | 24 | Signed filtered sample, registered |

## Verification
An impulse of 65536 reads the coefficient set out one tap per cycle. A wrong table entry, a broken mirror pairing or an off-by-one in the delay line therefore shows up as a specific wrong tap, or as a shifted sequence. An impulse of 1 drives every product far below the output LSB. This catches a design that rounds or truncates toward zero, because it would print 0 where -1 is due on the negative taps.

Alternating full-scale samples push the pre-adder and the tree to their extremes, where a missing sign extension flips the sign of the output. A reset in the middle of a random stream followed by a fresh impulse exposes a delay line that is not cleared, because stale samples would leak into the impulse response. A pipeline stage missing or added anywhere moves every expected value by one cycle, so the scoreboard fails from the first nonzero output.

// File: rtl/firPkg.sv
package firPkg;
  localparam int SAMPLE_W = 24;
  localparam int COEF_W   = 16;
  localparam int ACC_W    = 40;
  localparam int NTAPS    = 35;

  // number of registered adder levels needed to reduce n operands to one
  function automatic int treeDepth(input int n);
    int d;
    int c;
    d = 0;
    c = n;
    while (c > 1) begin
      c = (c + 1) / 2;
      d = d + 1;
    end
    return d;
  endfunction

  // operands remaining after l halving levels
  function automatic int levelCount(input int n, input int l);
    int c;
    c = n;
    for (int i = 0; i < l; i++) c = (c + 1) / 2;
    return c;
  endfunction

  // edges from input capture to registered output: line, pre-add, multiply, tree
  function automatic int pipeDepth(input int taps);
    return 3 + treeDepth((taps + 1) / 2);
  endfunction

  // symmetric coefficient set, folded onto the lower half
  function automatic logic signed [COEF_W-1:0] coefAt(input int k, input int taps);
    int m;
    m = (k > (taps - 1) / 2) ? (taps - 1 - k) : k;
    case (m)
      0:  return 16'sh015F;
      1:  return 16'sh0061;
      2:  return 16'sh0033;
      3:  return 16'shFFF0;
      4:  return 16'shFF8C;
      5:  return 16'shFED9;
      6:  return 16'shFE65;
      7:  return 16'shFE25;
      8:  return 16'shFE3B;
      9:  return 16'shFEBF;
      10: return 16'shFFA8;
      11: return 16'sh0120;
      12: return 16'sh02D8;
      13: return 16'sh04B3;
      14: return 16'sh067A;
      15: return 16'sh07F2;
      16: return 16'sh08EB;
      17: return 16'sh0942;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/firTapLine.sv
module firTapLine #(
  parameter int TAPS = 35,
  parameter int DW   = 24,
  localparam int NPAIR = TAPS / 2,
  localparam int NPRE  = (TAPS + 1) / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [DW-1:0] xIn,
  output logic signed [DW:0]   preSum [NPRE]
);
  logic signed [DW-1:0] line [TAPS];

  // line[0] is the input register; line[k] holds the sample k edges older
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) line[k] <= '0;
    end else begin
      line[0] <= xIn;
      for (int k = 1; k < TAPS; k++) line[k] <= line[k-1];
    end
  end

  // fold mirrored taps that share one coefficient
  for (genvar j = 0; j < NPAIR; j++) begin : gPair
    always_ff @(posedge clk) begin
      if (!rstN) preSum[j] <= '0;
      else preSum[j] <= {line[j][DW-1], line[j]} + {line[TAPS-1-j][DW-1], line[TAPS-1-j]};
    end
  end

  if (TAPS % 2 == 1) begin : gCentre
    always_ff @(posedge clk) begin
      if (!rstN) preSum[NPAIR] <= '0;
      else preSum[NPAIR] <= {line[NPAIR][DW-1], line[NPAIR]};
    end
  end
endmodule

// File: rtl/firMulStage.sv
module firMulStage #(
  parameter int N    = 18,
  parameter int IW   = 25,
  parameter int CW   = 16,
  parameter int AW   = 40,
  parameter int TAPS = 35
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [IW-1:0] preSum [N],
  output logic signed [AW-1:0] prod   [N]
);
  for (genvar j = 0; j < N; j++) begin : gMul
    localparam logic signed [CW-1:0] COEF = firPkg::coefAt(j, TAPS);
    logic signed [AW-1:0] opA;
    logic signed [AW-1:0] opC;
    assign opA = {{(AW-IW){preSum[j][IW-1]}}, preSum[j]};
    assign opC = {{(AW-CW){COEF[CW-1]}}, COEF};
    always_ff @(posedge clk) begin
      if (!rstN) prod[j] <= '0;
      else prod[j] <= opA * opC;
    end
  end
endmodule

// File: rtl/firAddTree.sv
module firAddTree #(
  parameter int N  = 18,
  parameter int AW = 40,
  localparam int LV = firPkg::treeDepth(N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [AW-1:0] leaf [N],
  output logic signed [AW-1:0] total
);
  logic signed [AW-1:0] node [1:LV][N];

  for (genvar l = 1; l <= LV; l++) begin : gLvl
    localparam int PREV = firPkg::levelCount(N, l - 1);
    localparam int CUR  = firPkg::levelCount(N, l);
    for (genvar i = 0; i < N; i++) begin : gNode
      if (i >= CUR) begin : gIdle
        always_ff @(posedge clk) node[l][i] <= '0;
      end else if (2*i + 1 < PREV) begin : gAdd
        if (l == 1) begin : gFirst
          always_ff @(posedge clk) begin
            if (!rstN) node[l][i] <= '0;
            else node[l][i] <= leaf[2*i] + leaf[2*i+1];
          end
        end else begin : gInner
          always_ff @(posedge clk) begin
            if (!rstN) node[l][i] <= '0;
            else node[l][i] <= node[l-1][2*i] + node[l-1][2*i+1];
          end
        end
      end else begin : gPass
        if (l == 1) begin : gFirst
          always_ff @(posedge clk) begin
            if (!rstN) node[l][i] <= '0;
            else node[l][i] <= leaf[2*i];
          end
        end else begin : gInner
          always_ff @(posedge clk) begin
            if (!rstN) node[l][i] <= '0;
            else node[l][i] <= node[l-1][2*i];
          end
        end
      end
    end
  end

  assign total = node[LV][0];
endmodule

// File: rtl/symFir.sv
module symFir #(
  parameter int TAPS = firPkg::NTAPS,
  parameter int DW   = firPkg::SAMPLE_W,
  parameter int CW   = firPkg::COEF_W,
  parameter int AW   = firPkg::ACC_W,
  localparam int NPRE = (TAPS + 1) / 2,
  localparam int PW   = DW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] xIn,
  output logic [DW-1:0] yOut
);
  logic signed [PW-1:0] preSum [NPRE];
  logic signed [AW-1:0] prod   [NPRE];
  logic signed [AW-1:0] acc;

  firTapLine #(.TAPS(TAPS), .DW(DW)) tapU (
    .clk(clk), .rstN(rstN), .xIn(xIn), .preSum(preSum)
  );

  firMulStage #(.N(NPRE), .IW(PW), .CW(CW), .AW(AW), .TAPS(TAPS)) mulU (
    .clk(clk), .rstN(rstN), .preSum(preSum), .prod(prod)
  );

  firAddTree #(.N(NPRE), .AW(AW)) treeU (
    .clk(clk), .rstN(rstN), .leaf(prod), .total(acc)
  );

  // final tree level is the output register; keep the top DW bits
  assign yOut = acc[AW-1 -: DW];
endmodule

// File: rtl/firChecks.sv
module firChecks #(
  parameter int DW     = 24,
  parameter int WARM   = 7,
  parameter int SETTLE = 44
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] xIn,
  input logic [DW-1:0] yOut
);
  int sinceRst;
  int holdCnt;
  int zeroCnt;
  logic [DW-1:0] prevX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= 0;
      holdCnt  <= 0;
      zeroCnt  <= 0;
      prevX    <= '0;
    end else begin
      prevX <= xIn;
      if (sinceRst < 1000) sinceRst <= sinceRst + 1;
      if (xIn == prevX) begin
        if (holdCnt < 1000) holdCnt <= holdCnt + 1;
      end else holdCnt <= 0;
      if (xIn == '0) begin
        if (zeroCnt < 1000) zeroCnt <= zeroCnt + 1;
      end else zeroCnt <= 0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (yOut == '0));

  // R2
  warmup_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst <= WARM) |-> (yOut == '0));

  // R5
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt >= SETTLE) |-> $stable(yOut));

  // R4
  zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (zeroCnt >= SETTLE) |-> (yOut == '0));
endmodule

bind symFir firChecks #(
  .DW(DW),
  .WARM(firPkg::pipeDepth(TAPS) - 1),
  .SETTLE(TAPS + firPkg::pipeDepth(TAPS) + 1)
) chkU (
  .clk(clk), .rstN(rstN), .xIn(xIn), .yOut(yOut)
);

// File: tb/symFir_test.sv
module symFir_test;
  localparam int PERIOD = 10;
  localparam int TAPS   = 35;
  localparam int LAT    = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] xIn = '0;
  logic [23:0] yOut;

  int nChk = 0;
  int nBad = 0;

  // R3: lower half of the symmetric coefficient set
  int cTab [18] = '{351, 97, 51, -16, -116, -295, -411, -475, -453, -321,
                    -88, 288, 728, 1203, 1658, 2034, 2283, 2370};
  longint hist [TAPS];
  logic [23:0] expQ [$];
  string tagQ [$];

  symFir uut (.clk(clk), .rstN(rstN), .xIn(xIn), .yOut(yOut));

  always #(PERIOD/2) clk = ~clk;

  function automatic int mirror(input int k);
    return (k > 17) ? (34 - k) : k;
  endfunction

  // monitor: compare the output seen now with the oldest expected item
  task automatic monitor();
    logic [23:0] e;
    string t;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChk++;
      if (yOut !== e) begin
        nBad++;
        $display("FAIL %s: yOut=%0d expected %0d", t, $signed(yOut), $signed(e));
      end
    end
  endtask

  // driver: apply one sample and queue its bit-exact expected result
  task automatic drive(input logic [23:0] x, input string tag);
    longint acc;
    longint q;
    @(negedge clk);
    rstN = 1'b1;
    monitor();
    xIn = x;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(x));
    acc = 0;
    for (int k = 0; k < TAPS; k++) acc += longint'(cTab[mirror(k)]) * hist[k];
    q = acc >>> 16;
    expQ.push_back(q[23:0]);
    tagQ.push_back(tag);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    xIn  = '0;
    repeat (2) @(negedge clk);
    nChk++;
    if (yOut !== '0) begin
      nBad++;
      $display("FAIL R1: yOut=%0d expected 0", $signed(yOut));
    end
    expQ.delete();
    tagQ.delete();
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    // R2: output stays zero while the pipeline refills
    for (int k = 0; k < LAT; k++) begin
      expQ.push_back('0);
      tagQ.push_back("R2");
    end
  endtask

  task automatic impulse(input logic [23:0] amp, input string tag);
    drive(amp, tag);
    for (int k = 0; k < TAPS + 4; k++) drive('0, tag);
  endtask

  initial begin
    logic [31:0] r;
    resetDut();
    impulse(24'h010000, "R3");
    impulse(24'h000001, "R4");
    impulse(24'h800000, "R6");
    for (int k = 0; k < 50; k++) drive(24'd1000, "R5");
    for (int k = 0; k < 50; k++) drive(24'hFFF000, "R5");
    for (int k = 0; k < 60; k++) drive((k % 2 == 0) ? 24'h7FFFFF : 24'h800000, "R6");
    for (int k = 0; k < 50; k++) drive(24'h7FFFFF, "R6");
    for (int k = 0; k < 300; k++) begin
      r = $urandom;
      drive(r[23:0], "R7");
    end
    resetDut();
    impulse(24'h010000, "R1");
    for (int k = 0; k < LAT; k++) drive('0, "R7");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    nChk++;
    nBad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule